// File: doc/BRIEF.md
# Module Power State Transition Controller

This block owns the clock-enable and reset lines of a group of peripheral modules that share one always-on power domain. Each module has two registers. A control register holds the state software wants next. A status register reports the state the module is in now. Software stages the requested states first. It then commits them all with one command write, and the block walks every module in index order. Each module whose requested state differs from its current state is moved, one at a time.

While the walk runs, a busy flag reads 1. When it reads 0 again, every status register holds its module's new state, and the per-module clock-enable and reset outputs have followed. Software normally polls the busy flag and then the status field of each module it changed. Requests written during a walk are not lost, but a second command write issued while busy has no effect.

Top module: `modpwr_ctrl`

## Requirements
- R1: After reset, every status register reads 0 (disabled), the busy flag reads 0, every module clock enable is low and every module reset output is high.
- R2: State codes are 0 = disabled, 1 = synchronous reset and 3 = enabled. Disabled drives clock enable low and reset high. Synchronous reset drives clock enable high and reset high. Enabled drives clock enable high and reset low. The outputs follow a status change one clock later.
- R3: Register map. The command register is at byte 0x000 (bit 0 = start). The busy register is at 0x004 (bit 0 = busy). The control register of module i is at 0x100 + 4*i, and its status register is at 0x200 + 4*i. The state sits in bits [1:0] of both. Undefined bits read 0, and the command register reads 0. Read data appears one clock after the read strobe.
- R4: A control write stores bits [1:0] as the requested state and bit 9 as a per-module flag, and both read back as written. A write whose bits [1:0] equal 2 leaves the requested state unchanged but still updates bit 9.
- R5: A command write with bit 0 set while idle raises busy on the next clock. A command write while busy is ignored and does not restart or extend the walk.
- R6: When the walk ends, each module whose requested state differed holds that state in its status register. Other modules keep their state. Status never changes while busy is low.
- R7: With N modules, STEP cycles per moved module and k modules to move, busy stays high for exactly N + k*(STEP-1) clocks.
- R8: Writes to status registers and to the busy register change nothing.
- R9: No status register ever holds code 2, and no module ever has its reset released while its clock enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after rd_en |
| mod_clk_en | output | N | Per-module clock enable |
| mod_rst | output | N | Per-module reset, active high |

## Verification
On every cycle, the bound assertions check four things: an idle start command raises busy, the outputs track the one-cycle-old status decode, status is frozen while idle, and no illegal code or unsafe clock/reset pair appears. Some properties only the bench scenarios can show, through the register port and the module pins. These are the exact busy length for a given number of pending modules, the refusal of a second start while busy, the retention of the illegal code write, the read-back of the flag bit, and the final per-module states.

// File: rtl/modpwr_pkg.sv
package modpwr_pkg;
  localparam logic [1:0] ST_OFF  = 2'd0;
  localparam logic [1:0] ST_SRST = 2'd1;
  localparam logic [1:0] ST_ON   = 2'd3;
  localparam logic [1:0] ST_BAD  = 2'd2;

  localparam int FLAG_BIT = 9;

  // byte offsets of the register pages
  localparam int CMD_OFF  = 'h000;
  localparam int BUSY_OFF = 'h004;
  localparam int CTRL_PG  = 1;
  localparam int STAT_PG  = 2;
endpackage

// File: rtl/modpwr_seq.sv
module modpwr_seq
  import modpwr_pkg::*;
#(
  parameter int N    = 16,
  parameter int STEP = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2*N-1:0] tgt_vec,
  output logic           busy,
  output logic [2*N-1:0] cur_vec
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int CNT_W = (STEP > 1) ? $clog2(STEP) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEP - 1);

  logic [1:0]       cur_q [N];
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       tgt_at;
  logic             pend;

  assign tgt_at = tgt_vec[2*idx_q +: 2];
  assign pend   = (tgt_at != cur_q[idx_q]);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      idx_q <= '0;
      cnt_q <= '0;
      for (int i = 0; i < N; i++) cur_q[i] <= ST_OFF;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        idx_q <= '0;
        cnt_q <= '0;
      end
    end else begin
      if (pend && cnt_q != LAST_CNT) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        if (pend) cur_q[idx_q] <= tgt_at;
        cnt_q <= '0;
        if (idx_q == LAST_IDX) busy <= 1'b0;
        else                   idx_q <= idx_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_pack
    assign cur_vec[2*g +: 2] = cur_q[g];
  end
endmodule

// File: rtl/modpwr_drv.sv
module modpwr_drv
  import modpwr_pkg::*;
#(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*N-1:0] cur_vec,
  output logic [N-1:0]   clk_en,
  output logic [N-1:0]   rst_out
);
  for (genvar g = 0; g < N; g++) begin : g_mod
    logic [1:0] st;
    assign st = cur_vec[2*g +: 2];
    always_ff @(posedge clk) begin
      if (rst) begin
        clk_en[g]  <= 1'b0;
        rst_out[g] <= 1'b1;
      end else begin
        clk_en[g]  <= (st != ST_OFF);
        rst_out[g] <= (st != ST_ON);
      end
    end
  end
endmodule

// File: rtl/modpwr_ctrl.sv
module modpwr_ctrl
  import modpwr_pkg::*;
#(
  parameter int N    = 16,
  parameter int STEP = 4,
  parameter int AW   = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic [N-1:0]  mod_clk_en,
  output logic [N-1:0]  mod_rst
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int PG_W  = AW - 8;

  logic [1:0]     next_q [N];
  logic [N-1:0]   flag_q;
  logic [2*N-1:0] tgt_vec;
  logic [2*N-1:0] cur_vec;
  logic           busy;

  logic [PG_W-1:0]  page;
  logic [5:0]       slot;
  logic [IDX_W-1:0] sidx;
  logic             slot_ok;
  logic             ctrl_hit, stat_hit, go;
  logic             unused_bits;

  assign page     = addr[AW-1:8];
  assign slot     = addr[7:2];
  assign sidx     = slot[IDX_W-1:0];
  assign slot_ok  = (int'(slot) < N) && (addr[1:0] == 2'b00);
  assign ctrl_hit = slot_ok && (page == PG_W'(CTRL_PG));
  assign stat_hit = slot_ok && (page == PG_W'(STAT_PG));
  assign go       = wr_en && (addr == AW'(CMD_OFF)) && wdata[0];
  assign unused_bits = ^{wdata[31:10], wdata[8:2], slot};

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      for (int i = 0; i < N; i++) next_q[i] <= ST_OFF;
    end else if (wr_en && ctrl_hit) begin
      flag_q[sidx] <= wdata[FLAG_BIT];
      if (wdata[1:0] != ST_BAD) next_q[sidx] <= wdata[1:0];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_tgt
    assign tgt_vec[2*g +: 2] = next_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= '0;
      if (addr == AW'(BUSY_OFF)) rdata[0] <= busy;
      else if (ctrl_hit) begin
        rdata[1:0]      <= next_q[sidx];
        rdata[FLAG_BIT] <= flag_q[sidx];
      end else if (stat_hit) begin
        rdata[1:0] <= cur_vec[2*sidx +: 2];
      end
    end
  end

  modpwr_seq #(.N(N), .STEP(STEP)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (go),
    .tgt_vec (tgt_vec),
    .busy    (busy),
    .cur_vec (cur_vec)
  );

  modpwr_drv #(.N(N)) u_drv (
    .clk     (clk),
    .rst     (rst),
    .cur_vec (cur_vec),
    .clk_en  (mod_clk_en),
    .rst_out (mod_rst)
  );
endmodule

// File: rtl/modpwr_chk.sv
module modpwr_chk
  import modpwr_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic           go_bit,
  input logic           busy,
  input logic [2*N-1:0] cur_vec,
  input logic [N-1:0]   mod_clk_en,
  input logic [N-1:0]   mod_rst
);
  logic [N-1:0] exp_en, exp_rst;
  logic         bad_code;

  always_comb begin
    bad_code = 1'b0;
    for (int i = 0; i < N; i++) begin
      exp_en[i]  = (cur_vec[2*i +: 2] != ST_OFF);
      exp_rst[i] = (cur_vec[2*i +: 2] != ST_ON);
      if (cur_vec[2*i +: 2] == ST_BAD) bad_code = 1'b1;
    end
  end

  // R5
  go_start_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(CMD_OFF) && go_bit && !busy) |=> busy);

  // R2
  out_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mod_clk_en == $past(exp_en) && mod_rst == $past(exp_rst)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(cur_vec));

  // R9
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    !bad_code);

  // R9
  safe_pair_chk: assert property (@(posedge clk) disable iff (rst)
    ((~mod_clk_en) & (~mod_rst)) == '0);
endmodule

bind modpwr_ctrl modpwr_chk #(.N(N), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .addr       (addr),
  .go_bit     (wdata[0]),
  .busy       (busy),
  .cur_vec    (cur_vec),
  .mod_clk_en (mod_clk_en),
  .mod_rst    (mod_rst)
);

// File: tb/tb_modpwr_ctrl.sv
module tb_modpwr_ctrl;
  localparam int N    = 16;
  localparam int STEP = 4;
  localparam int AW   = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0, sb_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  mod_clk_en, mod_rst;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic        rd_d = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  modpwr_ctrl #(.N(N), .STEP(STEP), .AW(AW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .mod_clk_en(mod_clk_en), .mod_rst(mod_rst)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when scoreboard reads return
  always @(posedge clk) rd_d <= rd_en && sb_en;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) check(1'b0, "scoreboard underflow", rdata, 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata == e, t, rdata, e);
      end
    end
  end

  // all tasks start and end at a falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [AW-1:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; sb_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0; sb_en = 1'b0;
  endtask

  task automatic rd_now(input logic [AW-1:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic poll_busy(output int ones);
    logic [31:0] v;
    ones = 0;
    for (int k = 0; k < 500; k++) begin
      rd_now(12'h004, v);
      if (!v[0]) break;
      ones++;
    end
  endtask

  function automatic logic [AW-1:0] ctl(input int i);
    return AW'(12'h100 + 4*i);
  endfunction
  function automatic logic [AW-1:0] sts(input int i);
    return AW'(12'h200 + 4*i);
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL all requirements: watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int ones;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(mod_clk_en == '0, "R1 clk_en after reset", 32'(mod_clk_en), 0);
    check(mod_rst == '1, "R1 mod_rst after reset", 32'(mod_rst), 32'hFFFF);
    rd_exp(12'h004, 0, "R1 busy after reset");
    rd_exp(sts(0), 0, "R1 status0 after reset");
    rd_exp(sts(15), 0, "R1 status15 after reset");

    // R4 control write/readback with flag bit 9; R3 command reads 0
    wr(ctl(3), 32'h3);
    wr(ctl(5), 32'h201);
    rd_exp(ctl(5), 32'h201, "R4 ctrl5 readback with flag");
    rd_exp(ctl(3), 32'h3, "R4 ctrl3 readback");
    rd_exp(12'h000, 0, "R3 command reads zero");

    // R5/R7 two pending modules: 16 + 2*3 busy cycles
    wr(12'h000, 32'h1);
    poll_busy(ones);
    check(ones == N + 2*(STEP-1), "R7 busy length two pending", ones, N + 2*(STEP-1));
    rd_exp(sts(3), 32'h3, "R6 status3 enabled");
    rd_exp(sts(5), 32'h1, "R6 status5 sync reset");
    rd_exp(sts(4), 32'h0, "R6 status4 untouched");
    check(mod_clk_en == 16'h0028, "R2 clk_en pattern", 32'(mod_clk_en), 32'h28);
    check(mod_rst == 16'hFFF7, "R2 rst pattern", 32'(mod_rst), 32'hFFF7);

    // R7 nothing pending: busy for N cycles
    wr(12'h000, 32'h1);
    poll_busy(ones);
    check(ones == N, "R7 busy length none pending", ones, N);

    // R5 second start while busy is ignored
    wr(ctl(3), 32'h0);
    wr(12'h000, 32'h1);
    wr(12'h000, 32'h1);
    poll_busy(ones);
    check(ones == N + (STEP-1) - 1, "R5 start while busy ignored", ones, N + STEP - 2);
    rd_exp(sts(3), 32'h0, "R6 status3 disabled again");
    check(mod_clk_en[3] == 1'b0 && mod_rst[3] == 1'b1, "R2 module3 disabled pins",
          {mod_clk_en[3], mod_rst[3]}, 32'h1);

    // R4 code 2 keeps next state, flag still written
    wr(ctl(7), 32'h3);
    wr(ctl(7), 32'h202);
    rd_exp(ctl(7), 32'h203, "R4 code 2 keeps next state");

    // R8 writes to status and busy registers ignored
    wr(sts(4), 32'h3);
    wr(12'h004, 32'h1);
    rd_exp(sts(4), 0, "R8 status write ignored");
    rd_exp(12'h004, 0, "R8 busy write ignored");
    check(mod_clk_en[4] == 1'b0, "R8 module4 clock still off", 32'(mod_clk_en[4]), 0);

    // R9 code 2 never reaches status after a commit
    wr(12'h000, 32'h1);
    poll_busy(ones);
    check(ones == N + (STEP-1), "R7 busy length one pending", ones, N + STEP - 1);
    rd_exp(sts(7), 32'h3, "R9 status7 legal code");
    check(mod_clk_en[7] && !mod_rst[7], "R2 module7 enabled pins",
          {mod_clk_en[7], mod_rst[7]}, 32'h2);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule